// File: doc/BRIEF.md
# Single-Bit Alias Access Translator

This block sits between a processor data port and a single-port, word-wide synchronous memory. Each address window it watches is a 32 MB alias space. Every aligned 32-bit word in that space stands for one bit of a 1 MB bit-addressable region. There are two such windows, one for working memory and one for peripherals, and each has its own alias base and its own region base.

When the processor writes a word to an alias address, the block turns it into a read of the target word followed by a write-back. Only the addressed bit changes, and it takes the value of bit 0 of the write data. A lock output is held for the whole sequence so that an outside arbiter can keep other masters off the memory. When the processor reads an alias address, the block returns the addressed bit in bit 0 of the response. Accesses outside both windows go straight through to memory with the usual byte enables. Malformed accesses get an error response and cause no memory cycle at all.

The master side uses a request/ready handshake and allows one outstanding access. Each access ends with a response strobe that lasts one cycle.

Top module: `bitband_xlate`

## Requirements
- R1: An access outside both alias windows is a pass-through to the word address with the low two address bits cleared. A pass-through read returns the full memory word. A pass-through write stores the request data under its byte enables.
- R2: An alias address A in a window with alias base AB and region base RB selects the word at RB + 4·floor((A−AB)/128). The bit index inside that word is (A−AB)[6:2]: bits 6:5 give the byte lane and bits 4:2 give the bit within the byte.
- R3: An alias write reads the target word and then writes it back with all bits equal, except the mapped bit, which becomes bit 0 of the write data. Write data bits 31:1 have no effect, and the write-back byte enables are all ones.
- R4: For an alias write, bus_lock is high from the cycle of the internal read through the cycle of the write-back. No other memory cycle happens in between. bus_lock stays low for every other kind of access.
- R5: An alias read makes exactly one memory read and no write. It returns the mapped bit in rsp_rdata bit 0, with bits 31:1 zero.
- R6: An access is rejected with rsp_err=1, rsp_rdata zero and no memory cycle in these cases: an alias access that is not word-sized (req_size=2) or not aligned to 4 bytes; req_size=3; a misaligned pass-through halfword or word.
- R7: The two windows decode independently: alias base 0x2200_0000 maps to region 0x2000_0000, and alias base 0x4200_0000 maps to region 0x4000_0000. An address at or beyond alias base + 32 MB is not an alias.
- R8: req_ready is high only when the block is idle. It drops in the cycle after an accepted request and rises again in the cycle after the response.
- R9: Counting the cycle after the accepting edge as cycle 1, rsp_valid is high for exactly one cycle. That cycle is cycle 4 for an alias write, cycle 3 for an alias read or a pass-through read, cycle 2 for a pass-through write and cycle 1 for a rejected access.
- R10: During and right after reset, req_ready=1, rsp_valid=0, bus_lock=0 and mem_en=0.
- R11: Pass-through byte enables follow req_size (0 byte, 1 halfword, 2 word): a byte sets mem_be bit addr[1:0], a halfword sets 0011 or 1100 by addr[1], and a word sets 1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 32 | Read result |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid the cycle after a read |
| bus_lock | output | 1 | Held across an alias read-modify-write |

## Verification
The schedule is fixed and counted from the edge that accepts a request. The internal or pass-through read goes out in cycle 1. The captured data is worked on in cycle 2. The alias write-back happens in cycle 3. The response comes in cycle 4, 3, 2 or 1 depending on the kind of access, and req_ready comes back one cycle after that. For each access the bench model works out this per-cycle expectation from the address, size and direction alone. At the falling edge of every cycle up to the return of ready, it compares mem_en, mem_we, mem_addr, mem_be, mem_wdata, bus_lock, rsp_valid and req_ready against that expectation, so a cycle that comes early or late shows up as a mismatch. The response payload is checked only in its due cycle, against a reference memory that the bench updates on its own.

// File: rtl/bitband_pkg.sv
package bitband_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_MOD,
    ST_WR,
    ST_PASS,
    ST_RESP
  } bb_state_e;

  typedef enum logic [1:0] {
    K_PASS,
    K_ALIAS,
    K_ERR
  } bb_kind_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

endpackage

// File: rtl/bitband_window.sv
// Decodes one alias window: hit test, target word address, bit index.
module bitband_window #(
  parameter int ADDR_W = 32,
  parameter int REGION_LOG2 = 20,
  parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] word_addr,
  output logic [4:0]        bit_idx,
  output logic [1:0]        lane
);
  localparam int ALIAS_LOG2 = REGION_LOG2 + 5;

  logic [ADDR_W:0] diff;

  assign diff = {1'b0, addr} - {1'b0, ALIAS_BASE};
  // no borrow and below the window span
  assign hit = !diff[ADDR_W] && (diff[ADDR_W-1:ALIAS_LOG2] == '0);
  // 32 alias bytes per region byte, word-aligned target
  assign word_addr = REGION_BASE + ADDR_W'({diff[ALIAS_LOG2-1:7], 2'b00});
  // byte lane in bits 6:5, bit within byte in bits 4:2
  assign bit_idx = diff[6:2];
  assign lane = diff[1:0];

endmodule

// File: rtl/bitband_bitop.sv
// Single-bit insert and extract on one data word.
module bitband_bitop #(
  parameter int DATA_W = 32,
  parameter int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [IDX_W-1:0]  idx,
  input  logic              val,
  output logic [DATA_W-1:0] new_word,
  output logic              bit_out
);
  always_comb begin
    new_word = word;
    new_word[idx] = val;
  end

  assign bit_out = word[idx];

endmodule

// File: rtl/bitband_ctrl.sv
// Sequencer: idle, read, modify, write-back, pass-through and response.
module bitband_ctrl
  import bitband_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  bb_kind_e  kind,
  input  logic      new_write,
  input  logic      cur_write,
  output bb_state_e state,
  output logic      ready,
  output logic      lock,
  output logic      rsp_valid
);
  bb_state_e nxt;
  logic      nxt_locked;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          unique case (kind)
            K_ALIAS: nxt = ST_RD;
            K_PASS:  nxt = ST_PASS;
            default: nxt = ST_RESP;
          endcase
        end
      end
      ST_RD:   nxt = ST_MOD;
      ST_MOD:  nxt = cur_write ? ST_WR : ST_RESP;
      ST_WR:   nxt = ST_RESP;
      ST_PASS: nxt = cur_write ? ST_RESP : ST_MOD;
      ST_RESP: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    nxt_locked = 1'b0;
    if (nxt == ST_RD || nxt == ST_MOD || nxt == ST_WR)
      nxt_locked = (state == ST_IDLE) ? new_write : cur_write;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      ready     <= 1'b1;
      lock      <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state     <= nxt;
      ready     <= (nxt == ST_IDLE);
      lock      <= nxt_locked;
      rsp_valid <= (nxt == ST_RESP);
    end
  end

  AST_LOCK_NOT_IDLE: assert property (@(posedge clk) disable iff (rst)
    ready |-> !lock); // R4
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R9

endmodule

// File: rtl/bitband_xlate.sv
// Alias-window translator between a request/ready master and a sync memory.
module bitband_xlate
  import bitband_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_WIN = 2,
  parameter int REGION_LOG2 = 20,
  parameter logic [NUM_WIN*ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
  parameter logic [NUM_WIN*ADDR_W-1:0] REGION_BASES = {32'h4000_0000, 32'h2000_0000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  output logic              bus_lock
);
  localparam int DATA_W = 32;
  localparam int BE_W = DATA_W / 8;
  localparam int IDX_W = $clog2(DATA_W);

  // window decode
  logic [NUM_WIN-1:0] win_hit;
  logic [ADDR_W-1:0]  win_addr [NUM_WIN];
  logic [IDX_W-1:0]   win_idx  [NUM_WIN];
  logic [1:0]         win_lane [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    bitband_window #(
      .ADDR_W(ADDR_W),
      .REGION_LOG2(REGION_LOG2),
      .ALIAS_BASE(ALIAS_BASES[w*ADDR_W +: ADDR_W]),
      .REGION_BASE(REGION_BASES[w*ADDR_W +: ADDR_W])
    ) u_win (
      .addr(req_addr),
      .hit(win_hit[w]),
      .word_addr(win_addr[w]),
      .bit_idx(win_idx[w]),
      .lane(win_lane[w])
    );
  end

  logic              sel_hit;
  logic [ADDR_W-1:0] sel_addr;
  logic [IDX_W-1:0]  sel_idx;
  logic [1:0]        sel_lane;

  // lowest-numbered window wins on overlap
  always_comb begin
    sel_hit  = 1'b0;
    sel_addr = '0;
    sel_idx  = '0;
    sel_lane = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (win_hit[w]) begin
        sel_hit  = 1'b1;
        sel_addr = win_addr[w];
        sel_idx  = win_idx[w];
        sel_lane = win_lane[w];
      end
    end
  end

  // request classification
  bb_kind_e        acc_kind;
  logic [BE_W-1:0] pass_be;

  always_comb begin
    acc_kind = K_PASS;
    if (req_size == SZ_BAD) begin
      acc_kind = K_ERR;
    end else if (sel_hit) begin
      acc_kind = (req_size == SZ_WORD && sel_lane == 2'b00) ? K_ALIAS : K_ERR;
    end else begin
      unique case (req_size)
        SZ_HALF: if (req_addr[0]) acc_kind = K_ERR;
        SZ_WORD: if (|req_addr[1:0]) acc_kind = K_ERR;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (req_size)
      SZ_BYTE: pass_be = BE_W'(1) << req_addr[1:0];
      SZ_HALF: pass_be = req_addr[1] ? BE_W'(4'b1100) : BE_W'(4'b0011);
      default: pass_be = '1;
    endcase
  end

  // sequencer
  bb_state_e state;
  logic      accept;
  logic      wr_q;

  assign accept = req_valid && req_ready;

  bitband_ctrl u_ctrl (
    .clk(clk),
    .rst(rst),
    .start(accept),
    .kind(acc_kind),
    .new_write(req_write),
    .cur_write(wr_q),
    .state(state),
    .ready(req_ready),
    .lock(bus_lock),
    .rsp_valid(rsp_valid)
  );

  // datapath registers
  logic              alias_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              setval_q;
  logic [DATA_W-1:0] wdata_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] rd_word_q;
  logic [DATA_W-1:0] wr_word_q;
  logic [DATA_W-1:0] rsp_rdata_q;
  logic              rsp_err_q;
  logic [DATA_W-1:0] mod_word;
  logic              mod_bit;

  bitband_bitop #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bitop (
    .word(mem_rdata),
    .idx(idx_q),
    .val(setval_q),
    .new_word(mod_word),
    .bit_out(mod_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q        <= 1'b0;
      alias_q     <= 1'b0;
      addr_q      <= '0;
      idx_q       <= '0;
      setval_q    <= 1'b0;
      wdata_q     <= '0;
      be_q        <= '0;
      rd_word_q   <= '0;
      wr_word_q   <= '0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      if (accept) begin
        wr_q        <= req_write;
        alias_q     <= (acc_kind == K_ALIAS);
        addr_q      <= sel_hit ? sel_addr : {req_addr[ADDR_W-1:2], 2'b00};
        idx_q       <= sel_idx;
        setval_q    <= req_wdata[0];
        wdata_q     <= req_wdata;
        be_q        <= pass_be;
        rsp_err_q   <= (acc_kind == K_ERR);
        rsp_rdata_q <= '0;
      end
      if (state == ST_MOD) begin
        rd_word_q <= mem_rdata;
        wr_word_q <= mod_word;
        if (!wr_q) rsp_rdata_q <= alias_q ? DATA_W'(mod_bit) : mem_rdata;
      end
    end
  end

  // memory port decoded from registered state
  assign mem_en    = (state == ST_RD) || (state == ST_WR) || (state == ST_PASS);
  assign mem_we    = (state == ST_WR) || ((state == ST_PASS) && wr_q);
  assign mem_addr  = addr_q;
  assign mem_wdata = (state == ST_WR) ? wr_word_q : wdata_q;
  assign mem_be    = (state == ST_WR) ? '1 : be_q;
  assign rsp_rdata = rsp_rdata_q;
  assign rsp_err   = rsp_err_q;

  AST_RMW_SAME_WORD: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && bus_lock) |->
      ($past(mem_en, 2) && !$past(mem_we, 2) && $past(mem_addr, 2) == mem_addr)); // R4
  AST_RMW_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we && bus_lock) |-> ($countones(mem_wdata ^ rd_word_q) <= 1)); // R3
  AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !$past(mem_en)); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R8
  AST_ALIAS_RD_BIT0: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && alias_q && !wr_q) |-> (rsp_rdata[DATA_W-1:1] == '0)); // R5

endmodule

// File: tb/bitband_xlate_tb.sv
module bitband_xlate_tb;

  localparam logic [31:0] AB0 = 32'h2200_0000;
  localparam logic [31:0] RB0 = 32'h2000_0000;
  localparam logic [31:0] AB1 = 32'h4200_0000;
  localparam logic [31:0] RB1 = 32'h4000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [1:0] req_size = 2'd2;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic mem_en, mem_we;
  logic [31:0] mem_addr;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic bus_lock;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  bitband_xlate u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .bus_lock(bus_lock)
  );

  // bench memory and independent reference memory
  logic [31:0] bmem [logic [31:0]];
  logic [31:0] rmem [logic [31:0]];

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [3:0] be);
    logic [31:0] r;
    r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] bget(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] rget(input logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) bmem[mem_addr] = merge(bget(mem_addr), mem_wdata, mem_be);
      else mem_rdata <= bget(mem_addr);
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // behavioural alias mapping, worked out arithmetically
  function automatic void map_alias(input logic [31:0] a, output bit hit,
                                    output logic [31:0] tgt, output int idx);
    longint unsigned ab, rb, off, byte_off;
    hit = 0; tgt = '0; idx = 0;
    for (int w = 0; w < 2; w++) begin
      ab = (w == 0) ? AB0 : AB1;
      rb = (w == 0) ? RB0 : RB1;
      if (!hit && a >= ab && a < ab + 64'h0200_0000) begin
        off = a - ab;
        byte_off = off / 32;
        hit = 1;
        tgt = 32'(rb + (byte_off / 4) * 4);
        idx = int'((byte_off % 4) * 8 + (off % 32) / 4);
      end
    end
  endfunction

  function automatic logic [31:0] alias_of(input logic [31:0] ab, input int byte_off,
                                           input int bitn);
    return ab + 32'(byte_off * 32) + 32'(bitn * 4);
  endfunction

  task automatic txn(input bit wr, input logic [1:0] sz, input logic [31:0] addr,
                     input logic [31:0] wd, input string tg);
    bit hit, err;
    int idx, n;
    logic [31:0] tgt, waddr, old, nw, exp_rd, exp_wd;
    logic [3:0] be;
    logic [4:1] e_en, e_we, e_lock, e_rv;
    string rq, arq;
    map_alias(addr, hit, tgt, idx);
    err = (sz == 2'd3) || (hit && (sz != 2'd2 || addr[1:0] != 2'b00)) ||
          (!hit && sz == 2'd1 && addr[0]) || (!hit && sz == 2'd2 && addr[1:0] != 2'b00);
    waddr = hit ? tgt : {addr[31:2], 2'b00};
    old = rget(waddr);
    nw = old; exp_rd = '0; be = 4'hF; exp_wd = '0;
    arq = hit ? "R2" : "R1";
    if (err) begin
      n = 1; e_en = 4'b0000; e_we = 4'b0000; e_lock = 4'b0000; e_rv = 4'b0001; rq = "R6";
    end else if (hit && wr) begin
      n = 4; e_en = 4'b0101; e_we = 4'b0100; e_lock = 4'b0111; e_rv = 4'b1000; rq = "R3";
      nw[idx] = wd[0]; exp_wd = nw;
    end else if (hit) begin
      n = 3; e_en = 4'b0001; e_we = 4'b0000; e_lock = 4'b0000; e_rv = 4'b0100; rq = "R5";
      exp_rd = {31'b0, old[idx]};
    end else if (wr) begin
      n = 2; e_en = 4'b0001; e_we = 4'b0001; e_lock = 4'b0000; e_rv = 4'b0010; rq = "R1";
      if (sz == 2'd0) be = 4'b0001 << addr[1:0];
      else if (sz == 2'd1) be = addr[1] ? 4'b1100 : 4'b0011;
      nw = merge(old, wd, be); exp_wd = wd;
    end else begin
      n = 3; e_en = 4'b0001; e_we = 4'b0000; e_lock = 4'b0000; e_rv = 4'b0100; rq = "R1";
      exp_rd = old;
    end

    @(negedge clk);
    chk(req_ready === 1'b1, "R8", {tg, " ready before request"}, 32'(req_ready), 32'd1);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 1; k <= n; k++) begin
      if (k > 1) @(negedge clk);
      chk(mem_en === e_en[k], rq, {tg, " mem_en"}, 32'(mem_en), 32'(e_en[k]));
      chk(bus_lock === e_lock[k], "R4", {tg, " bus_lock"}, 32'(bus_lock), 32'(e_lock[k]));
      chk(rsp_valid === e_rv[k], "R9", {tg, " rsp_valid"}, 32'(rsp_valid), 32'(e_rv[k]));
      chk(req_ready === 1'b0, "R8", {tg, " ready while busy"}, 32'(req_ready), 32'd0);
      if (e_en[k]) begin
        chk(mem_we === e_we[k], rq, {tg, " mem_we"}, 32'(mem_we), 32'(e_we[k]));
        chk(mem_addr === waddr, arq, {tg, " mem_addr"}, mem_addr, waddr);
        if (e_we[k]) begin
          chk(mem_wdata === exp_wd, rq, {tg, " mem_wdata"}, mem_wdata, exp_wd);
          chk(mem_be === be, hit ? "R3" : "R11", {tg, " mem_be"}, 32'(mem_be), 32'(be));
        end
      end
      if (e_rv[k]) begin
        chk(rsp_err === err, "R6", {tg, " rsp_err"}, 32'(rsp_err), 32'(err));
        chk(rsp_rdata === exp_rd, rq, {tg, " rsp_rdata"}, rsp_rdata, exp_rd);
      end
    end
    if (wr && !err) rmem[waddr] = nw;
    @(negedge clk);
    chk(req_ready === 1'b1, "R8", {tg, " ready after response"}, 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R9", {tg, " response ends"}, 32'(rsp_valid), 32'd0);
    chk(mem_en === 1'b0, "R8", {tg, " idle memory"}, 32'(mem_en), 32'd0);
  endtask

  task automatic preload(input logic [31:0] a, input logic [31:0] d);
    bmem[a] = d;
    rmem[a] = d;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    preload(32'h2000_0000, 32'h1234_5678);
    preload(32'h2000_0010, 32'hFFFF_FFFF);
    preload(32'h4000_0100, 32'hA5A5_0000);
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(req_ready === 1'b1, "R10", "reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid === 1'b0, "R10", "reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk(bus_lock === 1'b0, "R10", "reset lock", 32'(bus_lock), 32'd0);
    chk(mem_en === 1'b0, "R10", "reset mem_en", 32'(mem_en), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready === 1'b1 && mem_en === 1'b0, "R10", "after reset", 32'(req_ready), 32'd1);

    // R3 set bit 0, clear bit 31 with upper data bits set, R2 lane mapping
    txn(1, 2'd2, alias_of(AB0, 0, 0), 32'h0000_0001, "set b0");
    txn(1, 2'd2, alias_of(AB0, 16 + 3, 7), 32'hFFFF_FFFE, "clear b31");
    txn(1, 2'd2, alias_of(AB0, 16 + 1, 2), 32'hFFFF_FFFE, "clear b10");
    txn(1, 2'd2, alias_of(AB0, 0, 3), 32'h8000_0000, "upper ignored");
    // R5 alias reads
    txn(0, 2'd2, alias_of(AB0, 16 + 3, 7), 32'h0, "read b31");
    txn(0, 2'd2, alias_of(AB0, 16 + 3, 6), 32'h0, "read b30");
    txn(0, 2'd2, alias_of(AB0, 0, 0), 32'h0, "read b0");
    // R2 last alias word of the window
    txn(1, 2'd2, AB0 + 32'h01FF_FFFC, 32'h1, "top word");
    txn(0, 2'd2, AB0 + 32'h01FF_FFFC, 32'h0, "top read");
    // R7 peripheral window
    txn(1, 2'd2, alias_of(AB1, 32'h102, 0), 32'h1, "R7 periph set");
    txn(0, 2'd2, alias_of(AB1, 32'h102, 0), 32'h0, "R7 periph read");
    txn(0, 2'd2, 32'h4000_0100, 32'h0, "R7 periph word");
    // R6 rejected accesses, then memory unchanged
    txn(1, 2'd2, AB0 + 32'h1, 32'h1, "R6 misaligned alias");
    txn(1, 2'd0, AB0 + 32'h4, 32'h1, "R6 byte alias");
    txn(0, 2'd3, 32'h2000_0000, 32'h0, "R6 bad size");
    txn(1, 2'd1, 32'h2000_0101, 32'hFFFF, "R6 odd half");
    txn(0, 2'd2, 32'h2000_0000, 32'h0, "R6 unchanged");
    // R7 just past the alias window is plain memory
    txn(1, 2'd2, AB0 + 32'h0200_0000, 32'hDEAD_BEEF, "R7 past window");
    txn(0, 2'd2, AB0 + 32'h0200_0000, 32'h0, "R7 past read");
    // R11 pass-through byte and halfword lanes, R1 readback
    txn(1, 2'd2, 32'h2000_0100, 32'h0102_0304, "R1 word");
    txn(1, 2'd0, 32'h2000_0103, 32'h7700_0000, "R11 byte3");
    txn(1, 2'd0, 32'h2000_0101, 32'h0000_5500, "R11 byte1");
    txn(1, 2'd1, 32'h2000_0100, 32'h0000_AABB, "R11 half0");
    txn(0, 2'd2, 32'h2000_0100, 32'h0, "R1 readback");
    // R3 R5 sweep over the lanes of one word
    for (int i = 0; i < 16; i++) begin
      txn(1, 2'd2, alias_of(AB0, 32'h40 + (i % 4), (i * 3) % 8), 32'(i % 2 == 0), "sweep wr");
    end
    for (int i = 0; i < 16; i++) begin
      txn(0, 2'd2, alias_of(AB0, 32'h40 + (i % 4), (i * 3) % 8), 32'h0, "sweep rd");
    end
    txn(0, 2'd2, 32'h2000_0040, 32'h0, "R1 sweep word");
    finish_run();
  end

endmodule